// File: doc/BRIEF.md
# Ordered Daisy-Chain Work Distributor

This block spreads a stream of work items across a chain of worker nodes and returns their results in the order the items arrived. A dispatcher at the head tags every accepted item with a target worker and a sequence tag. It sends the item down a forward chain of point-to-point registered links. Each node captures the incoming link in its own register. It then either passes the item to its local worker or retransmits it to the next node, so every wire has exactly one receiver.

Each worker applies a fixed transform with a parameterised pipeline latency. Finished results travel back to the dispatcher over a separate return chain, which runs from the last node through the earlier ones. A node puts its own result onto that chain only when nothing is arriving from upstream. Until then the result waits in a small local queue. At the dispatcher a reorder window parks results that arrive early and releases them strictly in issue order. The number of items in flight is limited by the size of that window. The target for each item is the worker with the fewest outstanding jobs.

Top module: `wd_distributor`

## Requirements
- R1: After reset, `in_ready_o` is 1 and `out_valid_o` is 0.
- R2: Results leave on the output in exactly the order in which their inputs were accepted.
- R3: Each accepted item goes to the worker with the fewest outstanding jobs, and ties go to the lowest worker index. A job counts as outstanding from its acceptance until its result leaves the output. With default parameters (latency 3) and an idle block, three items accepted on consecutive cycles go to workers 0, 1 and 2. Their results first appear 7, 9 and 11 cycles after their acceptance edges.
- R4: At most `ROB_DEPTH` items are in flight. With the output stalled, exactly `ROB_DEPTH` items are accepted, and then `in_ready_o` stays 0.
- R5: Under any pattern of input gaps and output backpressure, no item is lost and none is duplicated.
- R6: While `out_valid_o` is 1 and `out_ready_i` is 0, the next cycle keeps `out_valid_o` at 1 and `out_data_o` unchanged.
- R7: Each result equals its input rotated left by one bit, plus 1, modulo 2^DATA_W.
- R8: On the return chain, an item arriving from upstream takes priority, and a node's local result waits without loss until the upstream slot is empty.
- R9: A worker accepts a new item only while the number of items in its pipeline plus its local result queue is below `RFIFO_DEPTH`, so that queue never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input item valid |
| in_ready_o | output | 1 | Block can accept an input item |
| in_data_i | input | DATA_W | Input item payload |
| out_valid_o | output | 1 | Ordered result valid |
| out_ready_i | input | 1 | Consumer accepts the result |
| out_data_o | output | DATA_W | Result payload |

## Verification
The hardest case to reach from the ports is a collision on the return chain. A node must finish a result in the same cycle that an upstream node's result is passing through, and that must happen while the reorder window is nearly full. The stimulus gets there with hundreds of items sent with random gaps, while `out_ready_i` toggles randomly. Outstanding counts then drift apart, and the least-busy choice moves work across every node, so results from different nodes meet on the chain. A stalled-output phase fills the window completely. A short burst from idle pins the worker choice through the exact result latencies.

// File: rtl/wd_pkg.sv
package wd_pkg;
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wd_worker.sv
module wd_worker #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned TAG_W      = 3,
  parameter int unsigned LATENCY    = 3,
  parameter int unsigned FIFO_DEPTH = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [TAG_W+DATA_W-1:0] in_pkt_i,
  output logic                    res_valid_o,
  input  logic                    res_pop_i,
  output logic [TAG_W+DATA_W-1:0] res_pkt_o
);
  localparam int unsigned PAY_W = TAG_W + DATA_W;
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned PTR_W = wd_pkg::idx_w(FIFO_DEPTH);

  logic [LATENCY-1:0] pv;
  logic [PAY_W-1:0]   pd [LATENCY];
  logic [PAY_W-1:0]   mem [FIFO_DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   fcnt, occ;
  logic               take, push, pop;
  logic [DATA_W-1:0]  din, dres;

  assign in_ready_o = occ < CNT_W'(FIFO_DEPTH);
  assign take       = in_valid_i && in_ready_o;
  assign push       = pv[LATENCY-1];
  assign pop        = res_pop_i && (fcnt != '0);
  assign din        = in_pkt_i[DATA_W-1:0];
  assign dres       = {din[DATA_W-2:0], din[DATA_W-1]} + DATA_W'(1);

  for (genvar s = 0; s < LATENCY; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pv[0] <= 1'b0;
        else         pv[0] <= take;
      always_ff @(posedge clk_i)
        pd[0] <= {in_pkt_i[PAY_W-1:DATA_W], dres};
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pv[s] <= 1'b0;
        else         pv[s] <= pv[s-1];
      always_ff @(posedge clk_i)
        pd[s] <= pd[s-1];
    end
  end

  always_ff @(posedge clk_i) if (push) mem[wr_ptr] <= pd[LATENCY-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fcnt   <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      fcnt <= fcnt + CNT_W'(push) - CNT_W'(pop);
      occ  <= occ + CNT_W'(take) - CNT_W'(pop);
    end
  end

  assign res_valid_o = fcnt != '0;
  assign res_pkt_o   = mem[rd_ptr];

  assert_fifo_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |-> (fcnt < CNT_W'(FIFO_DEPTH)));
  assert_pop_only_filled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_pop_i |-> res_valid_o);
endmodule

// File: rtl/wd_node.sv
module wd_node #(
  parameter int unsigned NODE_ID    = 0,
  parameter int unsigned ID_W       = 2,
  parameter int unsigned TAG_W      = 3,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned LATENCY    = 3,
  parameter int unsigned FIFO_DEPTH = 2,
  localparam int unsigned PKT_W     = ID_W + TAG_W + DATA_W,
  localparam int unsigned RES_W     = TAG_W + DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fwd_valid_i,
  output logic             fwd_ready_o,
  input  logic [PKT_W-1:0] fwd_pkt_i,
  output logic             fwd_valid_o,
  input  logic             fwd_ready_i,
  output logic [PKT_W-1:0] fwd_pkt_o,
  input  logic             ret_valid_i,
  output logic             ret_ready_o,
  input  logic [RES_W-1:0] ret_pkt_i,
  output logic             ret_valid_o,
  input  logic             ret_ready_i,
  output logic [RES_W-1:0] ret_pkt_o
);
  logic             fq_v, fq_pop, mine, w_ready;
  logic [PKT_W-1:0] fq;
  logic             rq_v, can_load, w_res_v, w_pop;
  logic [RES_W-1:0] rq, w_res;

  // forward link register
  assign mine        = fq[PKT_W-1 -: ID_W] == ID_W'(NODE_ID);
  assign fq_pop      = fq_v && (mine ? w_ready : fwd_ready_i);
  assign fwd_ready_o = !fq_v || fq_pop;
  assign fwd_valid_o = fq_v && !mine;
  assign fwd_pkt_o   = fq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fq_v <= 1'b0;
      fq   <= '0;
    end else if (fwd_valid_i && fwd_ready_o) begin
      fq_v <= 1'b1;
      fq   <= fwd_pkt_i;
    end else if (fq_pop) begin
      fq_v <= 1'b0;
    end
  end

  wd_worker #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .LATENCY(LATENCY), .FIFO_DEPTH(FIFO_DEPTH)
  ) u_worker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (fq_v && mine),
    .in_ready_o (w_ready),
    .in_pkt_i   (fq[RES_W-1:0]),
    .res_valid_o(w_res_v),
    .res_pop_i  (w_pop),
    .res_pkt_o  (w_res)
  );

  // return link register: upstream traffic first, local result fills gaps
  assign can_load    = !rq_v || ret_ready_i;
  assign ret_ready_o = can_load;
  assign w_pop       = can_load && !ret_valid_i && w_res_v;
  assign ret_valid_o = rq_v;
  assign ret_pkt_o   = rq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rq_v <= 1'b0;
      rq   <= '0;
    end else if (can_load && ret_valid_i) begin
      rq_v <= 1'b1;
      rq   <= ret_pkt_i;
    end else if (w_pop) begin
      rq_v <= 1'b1;
      rq   <= w_res;
    end else if (ret_ready_i) begin
      rq_v <= 1'b0;
    end
  end

  assert_local_result_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && can_load && w_res_v) |=> w_res_v);
  assert_ret_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rq_v && !ret_ready_i) |=> (rq_v && $stable(rq)));
  assert_fwd_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fq_v && !fq_pop) |=> (fq_v && $stable(fq)));
endmodule

// File: rtl/wd_dispatch.sv
module wd_dispatch #(
  parameter int unsigned NUM_WORKERS = 4,
  parameter int unsigned ID_W        = 2,
  parameter int unsigned TAG_W       = 3,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ROB_DEPTH   = 8,
  localparam int unsigned PKT_W      = ID_W + TAG_W + DATA_W,
  localparam int unsigned RES_W      = TAG_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              fwd_valid_o,
  input  logic              fwd_ready_i,
  output logic [PKT_W-1:0]  fwd_pkt_o,
  input  logic              ret_valid_i,
  output logic              ret_ready_o,
  input  logic [RES_W-1:0]  ret_pkt_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o
);
  localparam int unsigned CNT_W = $clog2(ROB_DEPTH + 1);

  logic [CNT_W-1:0]     cnt [NUM_WORKERS];
  logic [CNT_W-1:0]     best, occ;
  logic [ID_W-1:0]      sel;
  logic                 dq_v, in_fire, out_fire, sel_bad;
  logic [PKT_W-1:0]     dq;
  logic [ROB_DEPTH-1:0] filled;
  logic [DATA_W-1:0]    rdata [ROB_DEPTH];
  logic [ID_W-1:0]      rwid  [ROB_DEPTH];
  logic [TAG_W-1:0]     head, tail, rtag;

  always_comb begin
    sel  = '0;
    best = cnt[0];
    for (int j = 1; j < NUM_WORKERS; j++)
      if (cnt[j] < best) begin
        best = cnt[j];
        sel  = ID_W'(j);
      end
  end

  assign in_ready_o  = (!dq_v || fwd_ready_i) && (occ < CNT_W'(ROB_DEPTH));
  assign in_fire     = in_valid_i && in_ready_o;
  assign fwd_valid_o = dq_v;
  assign fwd_pkt_o   = dq;
  assign ret_ready_o = 1'b1;  // every tag owns a reserved slot
  assign rtag        = ret_pkt_i[RES_W-1 -: TAG_W];
  assign out_valid_o = filled[head];
  assign out_data_o  = rdata[head];
  assign out_fire    = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_v <= 1'b0;
      dq   <= '0;
    end else if (in_fire) begin
      dq_v <= 1'b1;
      dq   <= {sel, tail, in_data_i};
    end else if (fwd_ready_i) begin
      dq_v <= 1'b0;
    end
  end

  for (genvar w = 0; w < NUM_WORKERS; w++) begin : g_cnt
    logic inc, dec;
    assign inc = in_fire && (sel == ID_W'(w));
    assign dec = out_fire && (rwid[head] == ID_W'(w));
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) cnt[w] <= '0;
      else         cnt[w] <= cnt[w] + CNT_W'(inc) - CNT_W'(dec);
  end

  always_ff @(posedge clk_i) begin
    if (in_fire)     rwid[tail]  <= sel;
    if (ret_valid_i) rdata[rtag] <= ret_pkt_i[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filled <= '0;
      head   <= '0;
      tail   <= '0;
      occ    <= '0;
    end else begin
      if (out_fire)    filled[head] <= 1'b0;
      if (ret_valid_i) filled[rtag] <= 1'b1;
      if (out_fire)    head <= head + 1'b1;
      if (in_fire)     tail <= tail + 1'b1;
      occ <= occ + CNT_W'(in_fire) - CNT_W'(out_fire);
    end
  end

  always_comb begin
    sel_bad = 1'b0;
    for (int j = 0; j < NUM_WORKERS; j++)
      if ((cnt[j] < cnt[sel]) || ((ID_W'(j) < sel) && (cnt[j] == cnt[sel])))
        sel_bad = 1'b1;
  end

  assert_least_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fire |-> !sel_bad);
  assert_window_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= CNT_W'(ROB_DEPTH));
  assert_no_dup_result_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i |-> !filled[rtag]);
  assert_head_in_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire |=> (head == $past(head) + 1'b1));
endmodule

// File: rtl/wd_distributor.sv
module wd_distributor #(
  parameter int unsigned NUM_WORKERS = 4,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ROB_DEPTH   = 8,
  parameter int unsigned LATENCY     = 3,
  parameter int unsigned RFIFO_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o
);
  localparam int unsigned ID_W  = wd_pkg::idx_w(NUM_WORKERS);
  localparam int unsigned TAG_W = $clog2(ROB_DEPTH);
  localparam int unsigned PKT_W = ID_W + TAG_W + DATA_W;
  localparam int unsigned RES_W = TAG_W + DATA_W;

  // link i of the forward chain feeds node i; link i of the return chain leaves node i
  logic             fwd_v [NUM_WORKERS+1];
  logic             fwd_r [NUM_WORKERS+1];
  logic [PKT_W-1:0] fwd_p [NUM_WORKERS+1];
  logic             ret_v [NUM_WORKERS+1];
  logic             ret_r [NUM_WORKERS+1];
  logic [RES_W-1:0] ret_p [NUM_WORKERS+1];
  logic             unused_tail;

  assign fwd_r[NUM_WORKERS] = 1'b1;
  assign ret_v[NUM_WORKERS] = 1'b0;
  assign ret_p[NUM_WORKERS] = '0;
  assign unused_tail        = ret_r[NUM_WORKERS] ^ (^fwd_p[NUM_WORKERS]);

  wd_dispatch #(
    .NUM_WORKERS(NUM_WORKERS), .ID_W(ID_W), .TAG_W(TAG_W),
    .DATA_W(DATA_W), .ROB_DEPTH(ROB_DEPTH)
  ) u_dispatch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_data_i  (in_data_i),
    .fwd_valid_o(fwd_v[0]),
    .fwd_ready_i(fwd_r[0]),
    .fwd_pkt_o  (fwd_p[0]),
    .ret_valid_i(ret_v[0]),
    .ret_ready_o(ret_r[0]),
    .ret_pkt_i  (ret_p[0]),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (out_data_o)
  );

  for (genvar i = 0; i < NUM_WORKERS; i++) begin : g_node
    wd_node #(
      .NODE_ID(i), .ID_W(ID_W), .TAG_W(TAG_W), .DATA_W(DATA_W),
      .LATENCY(LATENCY), .FIFO_DEPTH(RFIFO_DEPTH)
    ) u_node (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .fwd_valid_i(fwd_v[i]),
      .fwd_ready_o(fwd_r[i]),
      .fwd_pkt_i  (fwd_p[i]),
      .fwd_valid_o(fwd_v[i+1]),
      .fwd_ready_i(fwd_r[i+1]),
      .fwd_pkt_o  (fwd_p[i+1]),
      .ret_valid_i(ret_v[i+1]),
      .ret_ready_o(ret_r[i+1]),
      .ret_pkt_i  (ret_p[i+1]),
      .ret_valid_o(ret_v[i]),
      .ret_ready_i(ret_r[i]),
      .ret_pkt_o  (ret_p[i])
    );
  end

  assert_chain_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwd_v[NUM_WORKERS]);
  assert_out_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
endmodule

// File: tb/tb_wd_distributor.sv
module tb_wd_distributor;
  localparam int unsigned NW   = 4;
  localparam int unsigned DW   = 16;
  localparam int unsigned ROBD = 8;
  localparam int unsigned LAT  = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0;
  logic          in_ready_o;
  logic [DW-1:0] in_data_i = '0;
  logic          out_valid_o;
  logic          out_ready_i = 1'b0;
  logic [DW-1:0] out_data_o;

  int vectors = 0, fails = 0, cyc = 0, fired = 0;
  logic          rand_ready = 1'b0;
  logic          lat_mode = 1'b0;
  logic [DW-1:0] exp_q [$];
  int            fire_q [$];
  int            lat_q [$];

  wd_distributor #(.NUM_WORKERS(NW), .DATA_W(DW), .ROB_DEPTH(ROBD),
                   .LATENCY(LAT), .RFIFO_DEPTH(2)) dut (.*);

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [DW-1:0] model(input logic [DW-1:0] d);  // R7
    return {d[DW-2:0], d[DW-1]} + DW'(1);
  endfunction

  task automatic check(input string req, input int act, input int expv);
    vectors++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // driver: called at a negedge
  task automatic send(input logic [DW-1:0] d);
    in_valid_i = 1'b1;
    in_data_i  = d;
    while (!in_ready_o) @(negedge clk_i);
    exp_q.push_back(model(d));
    fire_q.push_back(cyc + 1);
    fired++;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  // random backpressure, driven away from both edges
  always @(posedge clk_i) if (rand_ready) #5 out_ready_i = ($urandom_range(0, 2) != 0);

  // monitor / scoreboard: R2 R5 R7
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) begin
        vectors++; fails++;
        $display("FAIL R5: actual extra result %0d expected none", out_data_o);
      end else begin
        logic [DW-1:0] e;
        int f;
        e = exp_q.pop_front();
        f = fire_q.pop_front();
        check("R2/R7 ordered result", int'(out_data_o), int'(e));
        if (lat_mode) lat_q.push_back(cyc - f);
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (5) @(negedge clk_i);
  endtask

  task automatic run_all();
    logic [DW-1:0] held;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 in_ready after reset", int'(in_ready_o), 1);
    check("R1 out_valid after reset", int'(out_valid_o), 0);

    // R3: burst from idle goes to workers 0,1,2
    out_ready_i = 1'b1;
    lat_mode = 1'b1;
    send(16'h8001);
    send(16'h1234);
    send(16'hFFFF);
    drain();
    lat_mode = 1'b0;
    check("R3 latency worker0", lat_q.size() > 0 ? lat_q[0] : -1, 4 + LAT);
    check("R3 latency worker1", lat_q.size() > 1 ? lat_q[1] : -1, 6 + LAT);
    check("R3 latency worker2", lat_q.size() > 2 ? lat_q[2] : -1, 8 + LAT);

    // R4 / R6: stalled output fills the window
    out_ready_i = 1'b0;
    fired = 0;
    fork
      for (int k = 0; k < 12; k++) send(DW'(k * 97 + 5));
    join_none
    repeat (60) @(negedge clk_i);
    check("R4 accepted with output stalled", fired, ROB_DEPTH_c());
    check("R4 in_ready low when full", int'(in_ready_o), 0);
    check("R6 out_valid while stalled", int'(out_valid_o), 1);
    held = out_data_o;
    repeat (4) @(negedge clk_i);
    check("R6 out_data stable while stalled", int'(out_data_o), int'(held));
    out_ready_i = 1'b1;
    while (fired < 12) @(negedge clk_i);
    drain();

    // R5 R8 R9: random gaps and random backpressure
    rand_ready = 1'b1;
    for (int k = 0; k < 400; k++) begin
      send(DW'($urandom));
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 6)) @(negedge clk_i);
    end
    rand_ready = 1'b0;
    @(posedge clk_i);
    #5 out_ready_i = 1'b1;
    drain();
    check("R5 all results returned", exp_q.size(), 0);
    check("R5 no result left", int'(out_valid_o), 0);
  endtask

  function automatic int ROB_DEPTH_c();
    return int'(ROBD);
  endfunction

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk_i);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule